// File: doc/BRIEF.md
# Chained Descriptor Sample DMA Engine

This block is the transfer engine beside a DSP core. Software places a chain of seven-word descriptors in the core's X data memory, writes the address of the first one into a pointer register and writes the start register. The engine then reads each descriptor in turn and moves samples between DSP memory and one of sixteen external circular sample buffers. After finishing a descriptor it follows the link held in that descriptor's first word.

Every descriptor carries its own buffer window, given as a base, an inclusive limit and a starting offset. It also carries a stride through that window, and a stride of zero re-reads or re-writes a single location. The engine does not convert sample widths. It only presents the selected buffer and format code to an external converter on the buffer side. When the descriptor marked as the last one completes, a status bit is raised and is driven out as an interrupt. Software clears it by writing a one.

Top module: `chain_dma`

## Requirements
- R1: After reset, busy, irq and every memory enable are 0, and register reads of the control (0xFFFFD6) and status (0xFFFFC5) addresses return 0.
- R2: Writing a value with bit 0 set to the start address 0xFFFFD5 while idle copies the pointer register and raises busy. Busy stays high until the block carrying the end-of-list bit completes. A start write while busy is ignored.
- R3: A descriptor is seven words read from consecutive addresses starting at the pointer, in this order: link, control, count, DSP address, buffer offset, buffer base and buffer limit. Link bit 14 marks end-of-list, and link bits 13:0 give the next descriptor's address.
- R4: Control bit 1 selects the direction, with 0 meaning buffer to DSP and 1 meaning DSP to buffer. Each sample is one read of the source and then, in the following cycle, one write of the data returned to the destination. Both memory ports return read data one cycle after the enable.
- R5: The buffer index starts at base plus offset and advances by the stride in control bits 17:14 after each sample. An index that passes the limit wraps to base plus the amount by which it passed limit+1. A stride of 0 keeps the same location.
- R6: The DSP address starts at the descriptor's DSP address word and increases by one per sample. memSel is 0 for 0x0000–0x17FF, 1 for 0x1800–0x27FF, 2 for 0x2800–0x37FF and 3 above that.
- R7: During every data access, bufSel carries control bits 8:5 and bufFmt carries control bits 12:10.
- R8: A descriptor whose count is 0, or whose format code is 4, 5 or 7, moves no data. The engine then follows its link, or stops if it is the last block.
- R9: Status bit 7 (0xFFFFC5) is set when the end-of-list block completes, and irq mirrors it. Writing 1 to bit 7 clears it, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R10: The pointer register at 0xFFFFD4 reads back its low 16 bits, and it may be written at any time. Control register bit 0 reads as busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 24 | Register address |
| regWrData | input | 24 | Register write data |
| regRdData | output | 24 | Register read data (combinational) |
| descAddr | output | 16 | Descriptor fetch address in X memory |
| descRdEn | output | 1 | Descriptor fetch enable |
| descRdData | input | 24 | Descriptor word, one cycle after enable |
| dspAddr | output | 16 | DSP-side sample address |
| memSel | output | 2 | DSP memory space decoded from dspAddr |
| dspRdEn | output | 1 | DSP-side read enable |
| dspWrEn | output | 1 | DSP-side write enable |
| dspRdData | input | 24 | DSP-side read data, one cycle after enable |
| dspWrData | output | 24 | DSP-side write data |
| bufAddr | output | 16 | Buffer-side sample index |
| bufSel | output | 4 | Selected external buffer |
| bufFmt | output | 3 | Sample format code for the converter |
| bufRdEn | output | 1 | Buffer-side read enable |
| bufWrEn | output | 1 | Buffer-side write enable |
| bufRdData | input | 24 | Buffer-side read data, one cycle after enable |
| bufWrData | output | 24 | Buffer-side write data |
| busy | output | 1 | Chain in progress |
| irq | output | 1 | End-of-list status bit |

## Verification
Two events can land in one cycle: the engine setting the end-of-list status bit, and a software write-one-to-clear of that same bit. The bench provokes the collision by holding a clear write on the register port in every cycle of a multi-descriptor chain. It expects irq to be high for exactly one cycle and low again afterwards, which shows that the set beat the clear and that the next clear took effect. A start write issued while a chain is still running is the second overlap. It is judged by checking that the second chain's destination is untouched, while the pointer register still reads back the new value.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int DirBit   = 1;
  localparam int SelLsb   = 5;
  localparam int SelW     = 4;
  localparam int FmtLsb   = 10;
  localparam int FmtW     = 3;
  localparam int StepLsb  = 14;
  localparam int StepW    = 4;
  localparam int EolBit   = 14;
  localparam int LinkW    = 14;
  localparam int NumWords = 7;
  localparam int IdxW     = 3;

  typedef struct packed {
    logic            loadPtr;
    logic            fetch;
    logic [IdxW-1:0] fetchIdx;
    logic            init;
    logic            step;
    logic            follow;
  } dmaCtl_t;
endpackage

// File: rtl/chain_dma_path.sv
module chain_dma_path
  import chain_dma_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaCtl_t           ctl,
  input  logic [ADDR_W-1:0] nextAddr,
  output logic [ADDR_W-1:0] descAddr,
  input  logic [DATA_W-1:0] descRdData,
  output logic [ADDR_W-1:0] dspAddr,
  output logic [1:0]        memSel,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [SelW-1:0]   bufSel,
  output logic [FmtW-1:0]   bufFmt,
  output logic              dirToBuf,
  output logic              skipXfer,
  output logic              lastSample,
  output logic              eolBit
);
  localparam int WLink = 0, WCtrl = 1, WCount = 2, WDsp = 3;
  localparam int WOff = 4, WBase = 5, WLim = 6;
  localparam logic [ADDR_W-1:0] YStart = ADDR_W'(16'h1800);
  localparam logic [ADDR_W-1:0] PStart = ADDR_W'(16'h2800);
  localparam logic [ADDR_W-1:0] PEnd   = ADDR_W'(16'h3800);

  logic [DATA_W-1:0] desc [NumWords];
  logic              capValid;
  logic [IdxW-1:0]   capIdx;
  logic [ADDR_W-1:0] descPtr, dspPtr, bufIdx, nextIdx;
  logic [DATA_W-1:0] remain;
  logic [ADDR_W-1:0] winBase, winLim;
  logic [StepW-1:0]  stride;
  logic [ADDR_W:0]   sumIdx;

  assign winBase  = desc[WBase][ADDR_W-1:0];
  assign winLim   = desc[WLim][ADDR_W-1:0];
  assign stride   = desc[WCtrl][StepLsb +: StepW];
  assign dirToBuf = desc[WCtrl][DirBit];
  assign bufSel   = desc[WCtrl][SelLsb +: SelW];
  assign bufFmt   = desc[WCtrl][FmtLsb +: FmtW];
  assign eolBit   = desc[WLink][EolBit];
  assign skipXfer = (desc[WCount] == '0) || (bufFmt == 3'd4) ||
                    (bufFmt == 3'd5) || (bufFmt == 3'd7);
  assign lastSample = (remain == DATA_W'(1));
  assign descAddr = descPtr + ADDR_W'(ctl.fetchIdx);
  assign dspAddr  = dspPtr;
  assign bufAddr  = bufIdx;

  always_comb begin
    if (dspPtr < YStart)      memSel = 2'd0;
    else if (dspPtr < PStart) memSel = 2'd1;
    else if (dspPtr < PEnd)   memSel = 2'd2;
    else                      memSel = 2'd3;
  end

  always_comb begin
    sumIdx = {1'b0, bufIdx} + (ADDR_W+1)'(stride);
    if (sumIdx > {1'b0, winLim})
      nextIdx = winBase + (sumIdx[ADDR_W-1:0] - winLim - ADDR_W'(1));
    else
      nextIdx = sumIdx[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValid <= 1'b0;
      capIdx   <= '0;
      for (int w = 0; w < NumWords; w++) desc[w] <= '0;
    end else begin
      capValid <= ctl.fetch;
      capIdx   <= ctl.fetchIdx;
      for (int w = 0; w < NumWords; w++)
        if (capValid && capIdx == IdxW'(w)) desc[w] <= descRdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descPtr <= '0;
      dspPtr  <= '0;
      bufIdx  <= '0;
      remain  <= '0;
    end else begin
      if (ctl.loadPtr)     descPtr <= nextAddr;
      else if (ctl.follow) descPtr <= ADDR_W'(desc[WLink][LinkW-1:0]);
      if (ctl.init) begin
        bufIdx <= winBase + desc[WOff][ADDR_W-1:0];
        dspPtr <= desc[WDsp][ADDR_W-1:0];
        remain <= desc[WCount];
      end else if (ctl.step) begin
        bufIdx <= nextIdx;
        dspPtr <= dspPtr + ADDR_W'(1);
        remain <= remain - DATA_W'(1);
      end
    end
  end

  // R6: DSP pointer advances by exactly one per moved sample
  a_r6_dsp_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> dspPtr == $past(dspPtr) + ADDR_W'(1));
  // R5: a sample access never leaves the descriptor's window
  a_r5_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && winBase <= winLim) |-> (bufIdx >= winBase && bufIdx <= winLim));
  // R3: following a link loads link bits 13:0 as the next pointer
  a_r3_follow_link: assert property (@(posedge clk) disable iff (!rstN)
    ctl.follow |=> descPtr == ADDR_W'($past(desc[WLink][LinkW-1:0])));
endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import chain_dma_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 16,
  parameter int REG_AW = 24,
  parameter logic [REG_AW-1:0] NEXT_ADDR  = 24'hFFFFD4,
  parameter logic [REG_AW-1:0] START_ADDR = 24'hFFFFD5,
  parameter logic [REG_AW-1:0] CTRL_ADDR  = 24'hFFFFD6,
  parameter logic [REG_AW-1:0] STAT_ADDR  = 24'hFFFFC5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              skipXfer,
  input  logic              lastSample,
  input  logic              eolBit,
  output dmaCtl_t           ctl,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              xferRd,
  output logic              xferWr,
  output logic              busy,
  output logic              irq
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FLUSH, S_SETUP, S_RD, S_WR, S_DONE
  } state_t;

  state_t          state, stateNxt;
  logic [IdxW-1:0] fetchCnt;
  logic            statusEol;
  logic            startReq, clearReq, setEol;

  assign busy     = (state != S_IDLE);
  assign irq      = statusEol;
  assign startReq = regWrEn && regAddr == START_ADDR && regWrData[0];
  assign clearReq = regWrEn && regAddr == STAT_ADDR && regWrData[7];
  assign setEol   = (state == S_DONE) && eolBit;
  assign xferRd   = (state == S_RD);
  assign xferWr   = (state == S_WR);

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    ctl.fetchIdx = fetchCnt;
    unique case (state)
      S_IDLE:  if (startReq) begin ctl.loadPtr = 1'b1; stateNxt = S_FETCH; end
      S_FETCH: begin
        ctl.fetch = 1'b1;
        if (fetchCnt == IdxW'(NumWords - 1)) stateNxt = S_FLUSH;
      end
      S_FLUSH: stateNxt = S_SETUP;
      S_SETUP: begin
        ctl.init = 1'b1;
        stateNxt = skipXfer ? S_DONE : S_RD;
      end
      S_RD:    stateNxt = S_WR;
      S_WR: begin
        ctl.step = 1'b1;
        stateNxt = lastSample ? S_DONE : S_RD;
      end
      S_DONE: begin
        if (eolBit) stateNxt = S_IDLE;
        else begin ctl.follow = 1'b1; stateNxt = S_FETCH; end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      fetchCnt  <= '0;
      statusEol <= 1'b0;
      nextAddr  <= '0;
    end else begin
      state <= stateNxt;
      fetchCnt <= (state == S_FETCH && fetchCnt != IdxW'(NumWords - 1)) ?
                  fetchCnt + IdxW'(1) : '0;
      if (setEol)        statusEol <= 1'b1;
      else if (clearReq) statusEol <= 1'b0;
      if (regWrEn && regAddr == NEXT_ADDR) nextAddr <= regWrData[ADDR_W-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == NEXT_ADDR)      regRdData = DATA_W'(nextAddr);
    else if (regAddr == CTRL_ADDR) regRdData = DATA_W'(busy);
    else if (regAddr == STAT_ADDR) regRdData = DATA_W'({statusEol, 7'b0});
  end

  // R9: completion of the last block always leaves the status bit set
  a_r9_eol_set: assert property (@(posedge clk) disable iff (!rstN)
    setEol |=> statusEol);
  // R2: busy only drops when the end-of-list block completes
  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !setEol) |=> busy);
  // R8: a skipped descriptor goes straight to completion
  a_r8_skip_direct: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SETUP && skipXfer) |=> (state == S_DONE));
  // R4: every source read is followed by a destination write
  a_r4_rd_then_wr: assert property (@(posedge clk) disable iff (!rstN)
    xferRd |=> xferWr);
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 16,
  parameter int REG_AW = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] descAddr,
  output logic              descRdEn,
  input  logic [DATA_W-1:0] descRdData,
  output logic [ADDR_W-1:0] dspAddr,
  output logic [1:0]        memSel,
  output logic              dspRdEn,
  output logic              dspWrEn,
  input  logic [DATA_W-1:0] dspRdData,
  output logic [DATA_W-1:0] dspWrData,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [3:0]        bufSel,
  output logic [2:0]        bufFmt,
  output logic              bufRdEn,
  output logic              bufWrEn,
  input  logic [DATA_W-1:0] bufRdData,
  output logic [DATA_W-1:0] bufWrData,
  output logic              busy,
  output logic              irq
);
  dmaCtl_t           ctl;
  logic [ADDR_W-1:0] nextAddr;
  logic              xferRd, xferWr, dirToBuf, skipXfer, lastSample, eolBit;

  chain_dma_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .skipXfer(skipXfer),
    .lastSample(lastSample), .eolBit(eolBit), .ctl(ctl), .nextAddr(nextAddr),
    .xferRd(xferRd), .xferWr(xferWr), .busy(busy), .irq(irq));

  chain_dma_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .nextAddr(nextAddr),
    .descAddr(descAddr), .descRdData(descRdData), .dspAddr(dspAddr),
    .memSel(memSel), .bufAddr(bufAddr), .bufSel(bufSel), .bufFmt(bufFmt),
    .dirToBuf(dirToBuf), .skipXfer(skipXfer), .lastSample(lastSample),
    .eolBit(eolBit));

  assign descRdEn  = ctl.fetch;
  assign dspRdEn   = xferRd && dirToBuf;
  assign bufRdEn   = xferRd && !dirToBuf;
  assign dspWrEn   = xferWr && !dirToBuf;
  assign bufWrEn   = xferWr && dirToBuf;
  assign dspWrData = bufRdData;
  assign bufWrData = dspRdData;

  // R4: at most one destination written per cycle
  a_r4_one_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dspWrEn, bufWrEn}));
endmodule

// File: tb/chain_dma_bench.sv
module chain_dma_bench;
  localparam logic [23:0] A_NEXT = 24'hFFFFD4, A_START = 24'hFFFFD5;
  localparam logic [23:0] A_CTRL = 24'hFFFFD6, A_STAT = 24'hFFFFC5;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [23:0] regAddr = '0, regWrData = '0, regRdData;
  logic [15:0] descAddr, dspAddr, bufAddr;
  logic descRdEn, dspRdEn, dspWrEn, bufRdEn, bufWrEn, busy, irq;
  logic [23:0] descRdData, dspRdData, dspWrData, bufRdData, bufWrData;
  logic [1:0] memSel;
  logic [3:0] bufSel;
  logic [2:0] bufFmt;

  always #5 clk = ~clk;

  chain_dma u_chain_dma (.*);

  logic [23:0] xMem   [0:255];
  logic [23:0] dspMem [0:16383];
  logic [23:0] bufMem [0:4095];

  always @(posedge clk) begin
    if (descRdEn) descRdData <= xMem[descAddr[7:0]];
    if (dspRdEn)  dspRdData  <= dspMem[dspAddr[13:0]];
    if (bufRdEn)  bufRdData  <= bufMem[{bufSel, bufAddr[7:0]}];
    if (dspWrEn)  dspMem[dspAddr[13:0]] <= dspWrData;
    if (bufWrEn)  bufMem[{bufSel, bufAddr[7:0]}] <= bufWrData;
  end

  int vecs = 0, errs = 0, cycles = 0, monErr = 0;
  logic monOn = 1'b0;
  logic [3:0] expSel;
  logic [2:0] expFmt;

  function automatic logic [23:0] bufPat(logic [3:0] s, logic [7:0] a);
    return {4'hB, s, 8'h00, a};
  endfunction
  function automatic logic [23:0] dspPat(logic [13:0] a);
    return {10'h340, a};
  endfunction
  function automatic logic [1:0] spaceOf(logic [15:0] a);
    if (a < 16'h1800) return 2'd0;
    if (a < 16'h2800) return 2'd1;
    if (a < 16'h3800) return 2'd2;
    return 2'd3;
  endfunction
  function automatic logic [23:0] mkCtrl(logic d, logic [3:0] s, logic [2:0] f, logic [3:0] st);
    return (24'(d) << 1) | (24'(s) << 5) | (24'(f) << 10) | (24'(st) << 14);
  endfunction

  // R6/R7 monitor: memory space and buffer select/format on every access
  always @(negedge clk) if (monOn) begin
    if ((dspRdEn || dspWrEn) && memSel != spaceOf(dspAddr)) monErr++;
    if ((bufRdEn || bufWrEn) && (bufSel != expSel || bufFmt != expFmt)) monErr++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errs++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [23:0] a, input logic [23:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [23:0] a, output logic [23:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic putDesc(input int at, input logic [23:0] link, input logic [23:0] ctrl,
                         input int cnt, input int dsp, input int off, input int base, input int lim);
    xMem[at]   = link;        xMem[at+1] = ctrl;       xMem[at+2] = 24'(cnt);
    xMem[at+3] = 24'(dsp);    xMem[at+4] = 24'(off);   xMem[at+5] = 24'(base);
    xMem[at+6] = 24'(lim);
  endtask

  task automatic fillMems();
    for (int i = 0; i < 16384; i++) dspMem[i] = dspPat(14'(i));
    for (int i = 0; i < 4096; i++) bufMem[i] = bufPat(4'(i >> 8), 8'(i));
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  logic [23:0] rd;
  logic [23:0] expWin [0:255];

  initial begin
    for (int i = 0; i < 256; i++) xMem[i] = '0;
    fillMems();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !irq, "R1 busy/irq after reset", {22'b0, busy, irq}, 24'h0);
    chk(!dspWrEn && !bufWrEn && !descRdEn, "R1 enables idle", {21'b0, dspWrEn, bufWrEn, descRdEn}, 24'h0);
    rstN = 1'b1;
    @(negedge clk);
    regRead(A_CTRL, rd); chk(rd == 0, "R1 control reg", rd, 24'h0);
    regRead(A_STAT, rd); chk(rd == 0, "R1 status reg", rd, 24'h0);

    // R4 R5 R6 R7: sweep direction x stride x offset on an 8-entry window
    for (int dir = 0; dir < 2; dir++)
      for (int st = 0; st < 4; st++)
        for (int oi = 0; oi < 3; oi++) begin
          int off, dsp, idx, sel;
          int seq [0:5];
          logic [2:0] fmt;
          off = (oi == 0) ? 0 : (oi == 1) ? 3 : 7;
          fmt = (oi == 0) ? 3'd1 : (oi == 1) ? 3'd2 : 3'd6;
          sel = st * 2 + dir;
          dsp = ((st % 3 == 0) ? 16'h0040 : (st % 3 == 1) ? 16'h1840 : 16'h2840) + 16 * oi;
          fillMems();
          putDesc(0, 24'h004000, mkCtrl(dir[0], 4'(sel), fmt, 4'(st)), 6, dsp, off, 32'h20, 32'h27);
          expSel = 4'(sel); expFmt = fmt;
          idx = 32'h20 + off;
          for (int k = 0; k < 6; k++) begin
            seq[k] = idx;
            idx = idx + st;
            if (idx > 32'h27) idx = 32'h20 + (idx - 32'h27 - 1);
          end
          monOn = 1'b1;
          regWrite(A_NEXT, 24'h0);
          regWrite(A_START, 24'h1);
          chk(busy, "R2 busy after start", {23'b0, busy}, 24'h1);
          waitIdle();
          monOn = 1'b0;
          if (dir == 0) begin
            for (int k = 0; k < 6; k++)
              chk(dspMem[dsp + k] == bufPat(4'(sel), 8'(seq[k])), "R5 R4 buffer-to-DSP sample",
                  dspMem[dsp + k], bufPat(4'(sel), 8'(seq[k])));
          end else begin
            for (int a = 32'h20; a <= 32'h27; a++) expWin[a] = bufPat(4'(sel), 8'(a));
            for (int k = 0; k < 6; k++) expWin[seq[k]] = dspPat(14'(dsp + k));
            for (int a = 32'h20; a <= 32'h27; a++)
              chk(bufMem[sel * 256 + a] == expWin[a], "R5 R4 DSP-to-buffer window",
                  bufMem[sel * 256 + a], expWin[a]);
          end
          chk(irq, "R9 status set at end of list", {23'b0, irq}, 24'h1);
          regWrite(A_STAT, 24'h000000);
          chk(irq, "R9 writing 0 keeps status", {23'b0, irq}, 24'h1);
          regWrite(A_STAT, 24'h000080);
          chk(!irq, "R9 write-1 clears status", {23'b0, irq}, 24'h0);
        end
    chk(monErr == 0, "R6 R7 memSel/bufSel/bufFmt monitor", 24'(monErr), 24'h0);

    // R3 R8 R9: chain with count-zero and skipped-format blocks; clear held every cycle
    fillMems();
    putDesc(8'h00, 24'h000010, mkCtrl(1'b0, 4'd9, 3'd1, 4'd1), 2, 16'h0100, 0, 32'h40, 32'h4F);
    putDesc(8'h10, 24'h000020, mkCtrl(1'b0, 4'd9, 3'd1, 4'd1), 0, 16'h0200, 0, 32'h40, 32'h4F);
    putDesc(8'h20, 24'h000030, mkCtrl(1'b0, 4'd9, 3'd5, 4'd1), 3, 16'h0300, 0, 32'h40, 32'h4F);
    putDesc(8'h30, 24'h004000, mkCtrl(1'b0, 4'd9, 3'd1, 4'd1), 1, 16'h0400, 2, 32'h40, 32'h4F);
    expSel = 4'd9; expFmt = 3'd1;
    regWrite(A_NEXT, 24'h0);
    regWrite(A_START, 24'h1);
    begin
      int hiCnt = 0, guard = 0;
      @(negedge clk);
      regWrEn = 1'b1; regAddr = A_STAT; regWrData = 24'h80;
      while (busy && guard < 5000) begin @(negedge clk); guard++; if (irq) hiCnt++; end
      repeat (2) begin @(negedge clk); if (irq) hiCnt++; end
      regWrEn = 1'b0;
      chk(hiCnt == 1, "R9 set wins over same-cycle clear", 24'(hiCnt), 24'h1);
      chk(!irq, "R9 following clear takes effect", {23'b0, irq}, 24'h0);
    end
    chk(dspMem[16'h100] == bufPat(4'd9, 8'h40), "R3 first block sample 0", dspMem[16'h100], bufPat(4'd9, 8'h40));
    chk(dspMem[16'h101] == bufPat(4'd9, 8'h41), "R3 first block sample 1", dspMem[16'h101], bufPat(4'd9, 8'h41));
    chk(dspMem[16'h200] == dspPat(14'h200), "R8 count zero moves nothing", dspMem[16'h200], dspPat(14'h200));
    for (int k = 0; k < 3; k++)
      chk(dspMem[16'h300 + k] == dspPat(14'(16'h300 + k)), "R8 format 5 skipped",
          dspMem[16'h300 + k], dspPat(14'(16'h300 + k)));
    chk(dspMem[16'h400] == bufPat(4'd9, 8'h42), "R3 R8 link followed after skips",
        dspMem[16'h400], bufPat(4'd9, 8'h42));

    // R2 R10: start while busy ignored; pointer written while busy reads back
    fillMems();
    putDesc(8'h50, 24'h004000, mkCtrl(1'b1, 4'd3, 3'd1, 4'd1), 4, 16'h0500, 0, 32'h60, 32'h6F);
    putDesc(8'h60, 24'h004000, mkCtrl(1'b0, 4'd4, 3'd1, 4'd1), 2, 16'h0600, 0, 32'h60, 32'h6F);
    regWrite(A_NEXT, 24'h50);
    regWrite(A_START, 24'h1);
    regRead(A_CTRL, rd); chk(rd == 24'h1, "R10 control busy bit", rd, 24'h1);
    regWrite(A_NEXT, 24'h60);
    regWrite(A_START, 24'h1);
    waitIdle();
    regRead(A_NEXT, rd); chk(rd == 24'h60, "R10 pointer readback", rd, 24'h60);
    regRead(A_CTRL, rd); chk(rd == 24'h0, "R2 busy low after end of list", rd, 24'h0);
    for (int k = 0; k < 4; k++)
      chk(bufMem[3 * 256 + 32'h60 + k] == dspPat(14'(16'h500 + k)), "R2 first chain done",
          bufMem[3 * 256 + 32'h60 + k], dspPat(14'(16'h500 + k)));
    chk(dspMem[16'h600] == dspPat(14'h600), "R2 start while busy ignored", dspMem[16'h600], dspPat(14'h600));
    regWrite(A_STAT, 24'h80);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule